// File: doc/BRIEF.md
# DMA Descriptor Chain Loader

This block sits between a set of DMA channels and on-chip memory and fetches the next transfer descriptor for any channel that asks for one. A channel pulses its request strobe together with its current chain-pointer value. The block holds that request pending until it is the highest-priority one and no other fetch is running. It then reads the descriptor from memory one word per cycle, starting at the chain pointer plus a fixed base offset and moving down one word address per read. Each returned word goes out on a shared register-write bus, with a strobe for the owning channel and a slot number. When the last word has been written, the channel receives a one-cycle done pulse.

Two parameter masks set up each channel. One mask says whether the channel may chain at all; a channel left out of it has its request ignored. The other mask picks a short descriptor of 4 words or a full descriptor of 8 words. Once a fetch has started, it always runs to its last word. A request from a more urgent channel waits until that fetch is finished.

Top module: `cl_chain_loader`

## Requirements
- R1: A request strobe on a chaining channel is latched and kept pending until that channel is served. Every latched request produces exactly one descriptor load, and that load uses the chain-pointer value presented with the strobe.
- R2: When more than one request is pending and the block is idle, the pending channel with the lowest index is granted first.
- R3: A load that has started is not interrupted. All of its register writes belong to one channel and carry consecutive slot numbers, even if a higher-priority request arrives during the load.
- R4: The first read of a load uses address (chain pointer + 0x80000) modulo 2^ADDR_W. Each later read of the same load is at the previous address minus 1, with wrap-around. Reads are issued on back-to-back cycles.
- R5: A channel whose bit is set in SHORT_MASK performs 4 reads and 4 writes per load. Any other chaining channel performs 8 reads and 8 writes per load.
- R6: One cycle after each read, the block raises exactly one `reg_we_o` bit, the bit of the granted channel. In the same cycle `reg_sel_o` carries the word index (0 for the first word read, counting up), and `reg_wdata_o` carries the memory data returned for that read. For short descriptors, slots 0..3 are the index, modifier, count and next chain pointer.
- R7: `done_o` of the granted channel is high for exactly one cycle, in the cycle of the last register write. It is low at all other times.
- R8: A channel whose bit is clear in CHAIN_MASK is ignored. Its request causes no read, no write and no done pulse.
- R9: A request from a channel while that channel's own load is in progress is held. It causes one further load of that channel after the current one, using the newly presented chain pointer.
- R10: A synchronous active-high `rst` clears all pending requests and stops any load in progress. After reset, `mem_rd_o`, `reg_we_o` and `done_o` are low until a new request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_CH | One-cycle chain-load request strobe per channel |
| cp_i | input | NUM_CH*ADDR_W | Chain pointer per channel, channel c in bits c*ADDR_W +: ADDR_W, sampled with its strobe |
| done_o | output | NUM_CH | One-cycle load-complete pulse per channel |
| mem_rd_o | output | 1 | Memory read enable |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_rdata_i | input | DATA_W | Read data, valid one cycle after the read |
| reg_we_o | output | NUM_CH | Register write strobe per channel |
| reg_sel_o | output | 3 | Descriptor slot being written |
| reg_wdata_o | output | DATA_W | Descriptor word being written |

## Verification
Simultaneous requests from several channels show whether the grant order follows the channel index and not the order of arrival. A higher-priority request that arrives during a full-length load, and a repeated request from the channel that is being loaded, tell apart a loader that finishes first from one that switches channels or drops the repeat. A chain pointer near the top of the address space exposes address arithmetic that does not wrap, and a request on a non-chaining channel shows whether tied-off inputs leak through. Random request streams with varied gaps and pointers check that the memory model's address-tagged data arrives in the right slot for both descriptor lengths.

// File: rtl/cl_pkg.sv
package cl_pkg;

    typedef enum logic {
        CL_IDLE = 1'b0,
        CL_LOAD = 1'b1
    } cl_state_e;

    localparam int unsigned CL_FULL_WORDS  = 8;
    localparam int unsigned CL_SHORT_WORDS = 4;
    localparam int unsigned CL_SLOT_W      = 3;

endpackage

// File: rtl/cl_prio_arb.sv
module cl_prio_arb #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o,
    output logic [N-1:0]  onehot_o
);

    always_comb begin
        any_o    = |req_i;
        idx_o    = '0;
        onehot_o = '0;
        // scan downward so the lowest set index wins
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
            end
        end
        if (any_o) begin
            onehot_o = N'(1) << idx_o;
        end
    end

endmodule

// File: rtl/cl_req_latch.sv
module cl_req_latch #(
    parameter int unsigned   N          = 4,
    parameter int unsigned   AW         = 24,
    parameter logic [N-1:0]  CHAIN_MASK = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    req_i,
    input  logic [N*AW-1:0] cp_i,
    input  logic [N-1:0]    clr_i,
    output logic [N-1:0]    pend_o,
    output logic [N*AW-1:0] cp_o
);

    typedef struct packed {
        logic [N-1:0]    pend;
        logic [N*AW-1:0] cp;
    } latch_s;

    latch_s       st_d, st_q;
    logic [N-1:0] req_en;

    assign req_en = req_i & CHAIN_MASK;

    always_comb begin
        st_d      = st_q;
        // a strobe in the same cycle as a clear re-arms the channel
        st_d.pend = (st_q.pend & ~clr_i) | req_en;
        for (int i = 0; i < N; i++) begin
            if (req_en[i]) begin
                st_d.cp[i*AW +: AW] = cp_i[i*AW +: AW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign cp_o   = st_q.cp;

    AST_TIED_OFF_NEVER_PENDING: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend & ~CHAIN_MASK) == '0); // R8

    AST_STROBE_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (req_en != '0) |=> ((st_q.pend & $past(req_en)) == $past(req_en))); // R1

endmodule

// File: rtl/cl_chain_loader.sv
module cl_chain_loader #(
    parameter int unsigned       NUM_CH      = 4,
    parameter int unsigned       ADDR_W      = 24,
    parameter int unsigned       DATA_W      = 32,
    parameter logic [ADDR_W-1:0] BASE_OFFSET = ADDR_W'(32'h0008_0000),
    parameter logic [NUM_CH-1:0] CHAIN_MASK  = 4'b1011,
    parameter logic [NUM_CH-1:0] SHORT_MASK  = 4'b0110
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        req_i,
    input  logic [NUM_CH*ADDR_W-1:0] cp_i,
    output logic [NUM_CH-1:0]        done_o,
    output logic                     mem_rd_o,
    output logic [ADDR_W-1:0]        mem_addr_o,
    input  logic [DATA_W-1:0]        mem_rdata_i,
    output logic [NUM_CH-1:0]        reg_we_o,
    output logic [2:0]               reg_sel_o,
    output logic [DATA_W-1:0]        reg_wdata_o
);

    import cl_pkg::*;

    localparam int unsigned IW  = $clog2(NUM_CH);
    localparam int unsigned CNW = $clog2(CL_FULL_WORDS) + 1;

    typedef struct packed {
        cl_state_e              st;
        logic [IW-1:0]          gnt;
        logic [ADDR_W-1:0]      base;
        logic [CNW-1:0]         issue;
        logic                   rvalid;
        logic [CL_SLOT_W-1:0]   slot;
        logic                   last;
    } ctl_s;

    ctl_s                     ctl_d, ctl_q;
    logic [NUM_CH-1:0]        pend;
    logic [NUM_CH*ADDR_W-1:0] cp_held;
    logic [NUM_CH-1:0]        take;
    logic                     arb_any;
    logic [IW-1:0]            arb_idx;
    logic [NUM_CH-1:0]        arb_onehot;
    logic [CNW-1:0]           nwords;
    logic                     rd_now;

    function automatic logic [CNW-1:0] words_of(input logic [IW-1:0] ch);
        return SHORT_MASK[ch] ? CNW'(CL_SHORT_WORDS) : CNW'(CL_FULL_WORDS);
    endfunction

    cl_req_latch #(
        .N          (NUM_CH),
        .AW         (ADDR_W),
        .CHAIN_MASK (CHAIN_MASK)
    ) i_req_latch (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req_i),
        .cp_i   (cp_i),
        .clr_i  (take),
        .pend_o (pend),
        .cp_o   (cp_held)
    );

    cl_prio_arb #(
        .N  (NUM_CH),
        .IW (IW)
    ) i_prio_arb (
        .req_i    (pend),
        .any_o    (arb_any),
        .idx_o    (arb_idx),
        .onehot_o (arb_onehot)
    );

    assign nwords = words_of(ctl_q.gnt);
    assign rd_now = (ctl_q.st == CL_LOAD) && (ctl_q.issue < nwords);

    always_comb begin
        ctl_d  = ctl_q;
        take   = '0;
        ctl_d.rvalid = rd_now;
        ctl_d.slot   = ctl_q.issue[CL_SLOT_W-1:0];
        ctl_d.last   = rd_now && (ctl_q.issue == nwords - CNW'(1));
        case (ctl_q.st)
            CL_IDLE: begin
                if (arb_any) begin
                    take        = arb_onehot;
                    ctl_d.st    = CL_LOAD;
                    ctl_d.gnt   = arb_idx;
                    ctl_d.base  = cp_held[arb_idx*ADDR_W +: ADDR_W] + BASE_OFFSET;
                    ctl_d.issue = '0;
                end
            end
            CL_LOAD: begin
                if (rd_now) begin
                    ctl_d.issue = ctl_q.issue + CNW'(1);
                end
                if (ctl_q.rvalid && ctl_q.last) begin
                    ctl_d.st = CL_IDLE;
                end
            end
            default: ctl_d.st = CL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_rd_o    = rd_now;
    assign mem_addr_o  = ctl_q.base - ADDR_W'(ctl_q.issue);
    assign reg_sel_o   = ctl_q.slot;
    assign reg_wdata_o = mem_rdata_i;

    always_comb begin
        reg_we_o = '0;
        done_o   = '0;
        if (ctl_q.rvalid) begin
            reg_we_o[ctl_q.gnt] = 1'b1;
            done_o[ctl_q.gnt]   = ctl_q.last;
        end
    end

    AST_WRITE_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reg_we_o)); // R6

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |=> (reg_we_o != '0)); // R6

    AST_ADDR_STEPS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) - ADDR_W'(1))); // R4

    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == CL_LOAD && $past(ctl_q.st) == CL_LOAD) |-> $stable(ctl_q.gnt)); // R3

    AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
        (done_o != '0) |-> (done_o == reg_we_o)); // R7

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (done_o != '0) |=> (done_o == '0)); // R7

    AST_TIED_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        ((reg_we_o | done_o) & ~CHAIN_MASK) == '0); // R8

endmodule

// File: tb/test_cl_chain_loader.sv
module test_cl_chain_loader;

    localparam int NCH = 4;
    localparam int AW  = 24;
    localparam int DW  = 32;
    localparam logic [AW-1:0]  BASE  = 24'h08_0000;
    localparam logic [NCH-1:0] CHAIN = 4'b1011;
    localparam logic [NCH-1:0] SHORT = 4'b0110;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    req = '0;
    logic [NCH*AW-1:0] cp  = '0;
    logic [NCH-1:0]    done_o;
    logic              mem_rd_o;
    logic [AW-1:0]     mem_addr_o;
    logic [DW-1:0]     mem_rdata = '0;
    logic [NCH-1:0]    reg_we_o;
    logic [2:0]        reg_sel_o;
    logic [DW-1:0]     reg_wdata_o;

    always #2.5 clk = ~clk;

    cl_chain_loader #(
        .NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW), .BASE_OFFSET(BASE),
        .CHAIN_MASK(CHAIN), .SHORT_MASK(SHORT)
    ) i_cl_chain_loader (
        .clk(clk), .rst(rst), .req_i(req), .cp_i(cp), .done_o(done_o),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata),
        .reg_we_o(reg_we_o), .reg_sel_o(reg_sel_o), .reg_wdata_o(reg_wdata_o)
    );

    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
        return {8'h5A, a};
    endfunction

    function automatic int nw(input int c);
        return SHORT[c] ? 4 : 8;
    endfunction

    // memory model: one-cycle read latency, data tagged with its address
    always @(posedge clk) mem_rdata <= mem_rd_o ? word_of(mem_addr_o) : '0;

    int checks = 0, errors = 0;
    int pulses = 0, loads = 0, reads = 0, writes = 0, cyc = 0;
    logic [NCH-1:0] pend_b = '0;
    logic [AW-1:0]  cp_b [NCH];
    logic           active = 1'b0;
    int             cur_ch = 0, cur_slot = 0;
    logic [AW-1:0]  cur_base = '0, first_rd = '0;
    logic           prev_rd = 1'b0;
    int             order[$];

    task automatic chk(input bit ok, input string req_tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    // monitor, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_rd_o) begin
                reads++;
                if (!prev_rd) first_rd = mem_addr_o;
            end
            prev_rd = mem_rd_o;
            if (reg_we_o != '0) begin
                int ch;
                ch = 0;
                writes++;
                for (int i = 0; i < NCH; i++) if (reg_we_o[i]) ch = i;
                chk($onehot(reg_we_o), "R6 one strobe", reg_we_o, 1 << ch);
                chk(CHAIN[ch], "R8 write on tied-off channel", ch, 0);
                if (!active) begin
                    chk(reg_sel_o == 0, "R6 first slot", reg_sel_o, 0);
                    chk(pend_b[ch], "R1 load without request", ch, 0);
                    active   = 1'b1;
                    cur_ch   = ch;
                    cur_slot = 0;
                    cur_base = cp_b[ch] + BASE;
                    pend_b[ch] = 1'b0;
                    order.push_back(ch);
                    loads++;
                    chk(first_rd == cur_base, "R4 first address", first_rd, cur_base);
                end else begin
                    chk(ch == cur_ch, "R3 channel switched mid-load", ch, cur_ch);
                    chk(reg_sel_o == cur_slot + 1, "R3 slot sequence", reg_sel_o, cur_slot + 1);
                    cur_slot = reg_sel_o;
                end
                chk(reg_wdata_o == word_of(cur_base - AW'(reg_sel_o)), "R6 data/R4 address",
                    reg_wdata_o, word_of(cur_base - AW'(reg_sel_o)));
                if (int'(reg_sel_o) == nw(cur_ch) - 1) begin
                    chk(done_o == reg_we_o, "R7 done on last write (R5 length)", done_o, reg_we_o);
                    active = 1'b0;
                end else begin
                    chk(done_o == '0, "R7 early done", done_o, 0);
                end
            end else begin
                chk(done_o == '0, "R7 done without write", done_o, 0);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic pulse_set(input logic [NCH-1:0] m, input logic [AW-1:0] v);
        @(posedge clk); #1;
        for (int i = 0; i < NCH; i++) begin
            if (m[i]) begin
                req[i] = 1'b1;
                cp[i*AW +: AW] = v + AW'(i * 256);
                if (CHAIN[i]) begin
                    pend_b[i] = 1'b1;
                    cp_b[i]   = v + AW'(i * 256);
                    pulses++;
                end
            end
        end
        @(posedge clk); #1;
        req = '0;
    endtask

    task automatic wait_idle();
        int quiet;
        quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            if (pend_b == '0 && !active && !mem_rd_o) quiet++; else quiet = 0;
        end
    endtask

    task automatic wait_active(input int c);
        do @(negedge clk); while (!(active && cur_ch == c));
    endtask

    initial begin
        int base_n;
        for (int i = 0; i < NCH; i++) cp_b[i] = '0;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R10: reset in the middle of a load
        pulse_set(4'b0001, 24'h000100);
        wait_active(0);
        @(posedge clk); #1 rst = 1'b1;
        pulse_set(4'b0010, 24'h000200);
        @(posedge clk); #1 rst = 1'b0;
        pend_b = '0; active = 1'b0; prev_rd = 1'b0;
        @(negedge clk);
        chk(!mem_rd_o && reg_we_o == '0 && done_o == '0, "R10 idle after reset",
            {mem_rd_o, reg_we_o, done_o}, 0);
        reads = 0; writes = 0; loads = 0; pulses = 0; order.delete();
        repeat (20) @(negedge clk);
        chk(reads == 0 && loads == 0, "R10 pending cleared", reads + loads, 0);

        // R2: simultaneous requests served lowest index first
        base_n = order.size();
        pulse_set(4'b1011, 24'h001000);
        wait_idle();
        chk(order.size() == base_n + 3, "R2 load count", order.size() - base_n, 3);
        if (order.size() == base_n + 3) begin
            chk(order[base_n] == 0, "R2 first grant", order[base_n], 0);
            chk(order[base_n+1] == 1, "R2 second grant", order[base_n+1], 1);
            chk(order[base_n+2] == 3, "R2 third grant", order[base_n+2], 3);
        end

        // R3: higher-priority requests wait for a running full load
        base_n = order.size();
        pulse_set(4'b1000, 24'h002000);
        wait_active(3);
        pulse_set(4'b0011, 24'h003000);
        wait_idle();
        chk(order.size() == base_n + 3, "R3 load count", order.size() - base_n, 3);
        if (order.size() == base_n + 3) begin
            chk(order[base_n] == 3 && order[base_n+1] == 0 && order[base_n+2] == 1,
                "R3 order after non-preempted load",
                order[base_n] * 100 + order[base_n+1] * 10 + order[base_n+2], 301);
        end

        // R9: repeat request from the channel being loaded
        base_n = order.size();
        pulse_set(4'b0010, 24'h004000);
        wait_active(1);
        pulse_set(4'b0010, 24'h005500);
        wait_idle();
        chk(order.size() == base_n + 2, "R9 second load", order.size() - base_n, 2);

        // R8: tied-off channel is ignored
        base_n = reads;
        pulse_set(4'b0100, 24'h006000);
        repeat (30) @(negedge clk);
        chk(reads == base_n, "R8 no reads for tied-off channel", reads - base_n, 0);

        // R4: address wraps below zero
        pulse_set(4'b1000, 24'hF7FD02);
        wait_active(3);
        chk(cur_base == 24'h000002, "R4 wrapped base", cur_base, 24'h000002);
        wait_idle();

        // random stream
        for (int k = 0; k < 400; k++) begin
            int c;
            c = int'($urandom % NCH);
            if (!CHAIN[c] || (!pend_b[c] && !(active && cur_ch == c)))
                pulse_set(NCH'(1) << c, AW'($urandom));
            repeat ($urandom % 7) @(posedge clk);
        end
        wait_idle();

        chk(loads == pulses, "R1 one load per request", loads, pulses);
        chk(reads == writes, "R5 reads equal writes", reads, writes);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule